// File: doc/BRIEF.md
# USB Serial Transmit Engine

This block turns a stream of bytes into the serial symbol sequence of one USB packet. A byte source presents data on `tx_data` with `tx_valid` and hands each byte over on a clock edge where `tx_ready` is also high. The engine places the SYNC pattern ahead of the payload and shifts every byte out least significant bit first. It inserts a stuff bit after each run of six ones and NRZI-encodes the result. It then closes the packet with the end pattern that belongs to the selected speed. `hs_mode` selects full speed (low) or high speed (high). Its value is captured when a packet starts.

The serial side is paced by `bit_en`. Each clock with `bit_en` high moves one symbol to the registered outputs `line_dat` (NRZI level, 1 = J, 0 = K) and `line_se0` (single-ended zero). While no packet is in progress the outputs show the idle state of the selected speed.

The controller has five states. IDLE leads to SYNC_OUT when `tx_valid` is seen. SYNC_OUT leads to PAYLOAD once the last sync byte has left and a data byte is available. PAYLOAD reloads itself while bytes keep arriving. From SYNC_OUT or PAYLOAD the engine moves to TAIL_FS or TAIL_HS when a byte boundary finds no further byte. TAIL_FS and TAIL_HS both return to IDLE once their end pattern is complete.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset `tx_ready` is 0 and `line_dat` is 1. While idle, `line_dat` is 1 and `line_se0` follows `hs_mode`, so full-speed idle is J and high-speed idle is SE0.
- R2: `tx_valid` high in IDLE starts a packet and resets the NRZI level to J. In full-speed mode the sync byte 0x80 is sent, which appears on `line_dat` as K J K J K J K K (0,1,0,1,0,1,0,0).
- R3: In high-speed mode the sync is the four bytes 0x00, 0x00, 0x00, 0x80 in that order: 32 symbols.
- R4: Bytes are sent least significant bit first. NRZI encoding inverts `line_dat` for a 0 bit and keeps it for a 1 bit, and `line_se0` is 0 for every such symbol.
- R5: After six consecutive 1 bits (counted from the start of the sync) one extra inverting symbol is sent. It does not consume a data bit.
- R6: In full-speed mode the symbol after the last data bit is SE0, with no pending stuff bit. Two SE0 symbols (`line_se0`=1, `line_dat`=0) are followed by one J symbol, and then the line is idle.
- R7: In high-speed mode a stuff bit that falls due after the last data bit is still sent. Then the byte 0xFE goes out with stuffing disabled: one inverting symbol followed by seven unchanged ones. `line_se0` stays 0 until the line is idle.
- R8: A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` is high only in SYNC_OUT or PAYLOAD while the one-byte holding register is empty. Bytes are sent in the order they were taken.
- R9: Once `tx_valid` has been low during a packet, `tx_ready` stays low until the packet has ended.
- R10: During a packet the outputs change only on clocks with `bit_en` high. Each such clock sends exactly one symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_mode | input | 1 | 1 selects high speed, 0 full speed |
| bit_en | input | 1 | Bit-time strobe pacing the serial output |
| tx_data | input | 8 | Byte offered by the source |
| tx_valid | input | 1 | Source has a byte; its fall ends the packet |
| tx_ready | output | 1 | Engine takes `tx_data` on this edge if `tx_valid` is high |
| line_dat | output | 1 | NRZI line level, 1 = J, 0 = K |
| line_se0 | output | 1 | Single-ended zero on the line |

## Verification
The hardest case to reach is a stuff bit that falls due exactly at the end of the payload. There the two speeds part ways: high speed must still send the stuff bit ahead of the forced 0xFE byte, and full speed must drop it and go straight to SE0. Random bytes seldom end on six ones, so directed packets ending in 0xFC, and runs of 0xFF, are sent at both speeds. Random packets are weighted toward 0xFF and sent with strobe periods from one to four clocks, so that stuffing lands on byte boundaries and inside the sync-to-payload handover.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_OUT,
        ST_PAYLOAD,
        ST_TAIL_FS,
        ST_TAIL_HS
    } tx_state_e;

    typedef enum logic [2:0] {
        SYM_HOLD,
        SYM_IDLE,
        SYM_BIT,
        SYM_STUFF,
        SYM_SE0,
        SYM_J
    } sym_e;

endpackage

// File: rtl/usb_tx_shifter.sv
module usb_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    output logic              ser_bit,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= load_val;
            cnt  <= '0;
        end else if (shift) begin
            sreg <= sreg >> 1;
            cnt  <= cnt + CNT_W'(1);
        end
    end

    assign ser_bit  = sreg[0];
    assign last_bit = (cnt == CNT_W'(DATA_W - 1));
endmodule

// File: rtl/usb_tx_line_enc.sv
module usb_tx_line_enc
    import usb_tx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  sym_e sym,
    input  logic bit_val,
    input  logic count_en,
    input  logic clr_ones,
    input  logic lvl_reset,
    input  logic idle_se0,
    output logic stuff_due,
    output logic line_dat,
    output logic line_se0
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic             level;
    logic [RUN_W-1:0] ones;
    logic             bit_lvl;

    always_comb bit_lvl = bit_val ? level : ~level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level    <= 1'b1;
            ones     <= '0;
            line_dat <= 1'b1;
            line_se0 <= 1'b0;
        end else begin
            unique case (sym)
                SYM_HOLD: ;
                SYM_IDLE: begin
                    line_dat <= 1'b1;
                    line_se0 <= idle_se0;
                end
                SYM_BIT: begin
                    level    <= bit_lvl;
                    line_dat <= bit_lvl;
                    line_se0 <= 1'b0;
                    if (count_en)
                        ones <= bit_val ? ones + RUN_W'(1) : '0;
                end
                SYM_STUFF: begin
                    level    <= ~level;
                    line_dat <= ~level;
                    line_se0 <= 1'b0;
                    ones     <= '0;
                end
                SYM_SE0: begin
                    line_dat <= 1'b0;
                    line_se0 <= 1'b1;
                end
                SYM_J: begin
                    level    <= 1'b1;
                    line_dat <= 1'b1;
                    line_se0 <= 1'b0;
                end
                default: ;
            endcase
            if (lvl_reset) begin
                level <= 1'b1;
                ones  <= '0;
            end
            if (clr_ones)
                ones <= '0;
        end
    end

    assign stuff_due = (ones == RUN_W'(STUFF_RUN));
endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
    import usb_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int STUFF_RUN     = 6,
    parameter int HS_SYNC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_mode,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_dat,
    output logic              line_se0
);
    localparam int SYNC_W = (HS_SYNC_BYTES > 2) ? $clog2(HS_SYNC_BYTES) : 1;
    localparam logic [DATA_W-1:0] SYNC_PAD  = '0;
    localparam logic [DATA_W-1:0] SYNC_LAST = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] HS_TAIL   = {{(DATA_W-1){1'b1}}, 1'b0};

    tx_state_e         state, state_n;
    logic [SYNC_W-1:0] sync_left, sync_n;
    logic [1:0]        tail_cnt, tail_n;
    logic              mode_q, mode_n;
    logic              hold_full, ending;
    logic [DATA_W-1:0] hold;

    sym_e              sym;
    logic              bit_val, count_en, clr_ones, lvl_reset;
    logic              ld, sh, take_hold;
    logic [DATA_W-1:0] ld_val;
    logic              ser_bit, last_bit, stuff_due;
    logic              accept, avail;
    logic [DATA_W-1:0] next_byte;

    assign tx_ready  = ((state == ST_SYNC_OUT) || (state == ST_PAYLOAD)) && !hold_full && !ending;
    assign accept    = tx_valid && tx_ready;
    assign avail     = hold_full || accept;
    assign next_byte = hold_full ? hold : tx_data;

    // State register and packet bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sync_left <= '0;
            tail_cnt  <= '0;
            mode_q    <= 1'b0;
            hold_full <= 1'b0;
            hold      <= '0;
            ending    <= 1'b0;
        end else begin
            state     <= state_n;
            sync_left <= sync_n;
            tail_cnt  <= tail_n;
            mode_q    <= mode_n;
            if (take_hold)
                hold_full <= 1'b0;
            else if (accept) begin
                hold      <= tx_data;
                hold_full <= 1'b1;
            end
            if (state == ST_IDLE)
                ending <= 1'b0;
            else if (((state == ST_SYNC_OUT) || (state == ST_PAYLOAD)) && !tx_valid)
                ending <= 1'b1;
        end
    end

    // Next state and symbol selection
    always_comb begin
        state_n   = state;
        sync_n    = sync_left;
        tail_n    = tail_cnt;
        mode_n    = mode_q;
        sym       = SYM_HOLD;
        bit_val   = 1'b0;
        count_en  = 1'b1;
        clr_ones  = 1'b0;
        lvl_reset = 1'b0;
        ld        = 1'b0;
        ld_val    = '0;
        sh        = 1'b0;
        take_hold = 1'b0;
        unique case (state)
            ST_IDLE: begin
                sym = SYM_IDLE;
                if (tx_valid) begin
                    state_n   = ST_SYNC_OUT;
                    ld        = 1'b1;
                    ld_val    = hs_mode ? SYNC_PAD : SYNC_LAST;
                    sync_n    = hs_mode ? SYNC_W'(HS_SYNC_BYTES - 1) : '0;
                    mode_n    = hs_mode;
                    lvl_reset = 1'b1;
                end
            end
            ST_SYNC_OUT, ST_PAYLOAD: begin
                if (bit_en) begin
                    if (stuff_due) begin
                        sym = SYM_STUFF;
                    end else begin
                        sym     = SYM_BIT;
                        bit_val = ser_bit;
                        sh      = 1'b1;
                        if (last_bit) begin
                            ld = 1'b1;
                            if ((state == ST_SYNC_OUT) && (sync_left != '0)) begin
                                ld_val = (sync_left == SYNC_W'(1)) ? SYNC_LAST : SYNC_PAD;
                                sync_n = sync_left - SYNC_W'(1);
                            end else if (avail) begin
                                ld_val    = next_byte;
                                take_hold = 1'b1;
                                state_n   = ST_PAYLOAD;
                            end else begin
                                ld_val   = HS_TAIL;
                                tail_n   = '0;
                                state_n  = mode_q ? ST_TAIL_HS : ST_TAIL_FS;
                                clr_ones = !mode_q;
                            end
                        end
                    end
                end
            end
            ST_TAIL_FS: begin
                if (bit_en) begin
                    sym    = (tail_cnt == 2'd2) ? SYM_J : SYM_SE0;
                    tail_n = tail_cnt + 2'd1;
                    if (tail_cnt == 2'd2)
                        state_n = ST_IDLE;
                end
            end
            ST_TAIL_HS: begin
                if (bit_en) begin
                    if (stuff_due) begin
                        sym = SYM_STUFF;
                    end else begin
                        sym      = SYM_BIT;
                        bit_val  = ser_bit;
                        count_en = 1'b0;
                        sh       = 1'b1;
                        if (last_bit)
                            state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    usb_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .shift    (sh),
        .ser_bit  (ser_bit),
        .last_bit (last_bit)
    );

    usb_tx_line_enc #(.STUFF_RUN(STUFF_RUN)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym       (sym),
        .bit_val   (bit_val),
        .count_en  (count_en),
        .clr_ones  (clr_ones),
        .lvl_reset (lvl_reset),
        .idle_se0  (hs_mode),
        .stuff_due (stuff_due),
        .line_dat  (line_dat),
        .line_se0  (line_se0)
    );
endmodule

// File: rtl/usb_tx_checker.sv
module usb_tx_checker
    import usb_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      hs_mode,
    input logic      bit_en,
    input logic      tx_valid,
    input logic      tx_ready,
    input logic      line_dat,
    input logic      line_se0,
    input tx_state_e state,
    input logic      mode_q
);
    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE)
        |-> (line_dat && (line_se0 == $past(hs_mode))));

    p_no_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tx_ready);

    p_ready_low_after_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!tx_valid) && $past(state) != ST_IDLE && state != ST_IDLE) |-> !tx_ready);

    p_quiet_without_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE && !$past(bit_en))
        |-> ($stable(line_dat) && $stable(line_se0)));

    p_hs_no_se0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && $past(state) != ST_IDLE && state != ST_IDLE && mode_q)
        |-> !line_se0);

    p_fs_se0_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && $past(state) != ST_IDLE && state != ST_IDLE && line_se0)
        |-> (!line_dat && !mode_q));
endmodule

bind usb_tx_serializer usb_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_mode  (hs_mode),
    .bit_en   (bit_en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .line_dat (line_dat),
    .line_se0 (line_se0),
    .state    (state),
    .mode_q   (mode_q)
);

// File: tb/test_usb_tx_serializer.sv
`timescale 1ns/1ps
module test_usb_tx_serializer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       hs_mode;
    logic       bit_en;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic       line_dat;
    logic       line_se0;

    always #2.5 clk = ~clk;

    usb_tx_serializer i_usb_tx_serializer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_mode  (hs_mode),
        .bit_en   (bit_en),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .line_dat (line_dat),
        .line_se0 (line_se0)
    );

    int         checks   = 0;
    int         failures = 0;
    logic [7:0] pkt [0:15];
    int         plen;
    logic [1:0] exp_sym [0:255];
    int         exp_n;
    int         m_ones;
    logic       m_lvl;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic put_raw(input bit b);
        if (!b) m_lvl = ~m_lvl;
        exp_sym[exp_n] = {1'b0, m_lvl};
        exp_n++;
    endtask

    // R5: a pending stuff bit is sent before the next counted bit
    task automatic put_counted(input bit b);
        if (m_ones == 6) begin
            put_raw(1'b0);
            m_ones = 0;
        end
        put_raw(b);
        m_ones = b ? m_ones + 1 : 0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) put_counted(v[i]);
    endtask

    task automatic build_expected(input bit hs);
        exp_n  = 0;
        m_ones = 0;
        m_lvl  = 1'b1;
        if (hs) begin
            put_byte(8'h00); put_byte(8'h00); put_byte(8'h00);
        end
        put_byte(8'h80);
        for (int k = 0; k < plen; k++) put_byte(pkt[k]);
        if (hs) begin
            if (m_ones == 6) put_raw(1'b0);            // R7 trailing stuff bit
            put_raw(1'b0);
            for (int i = 1; i < 8; i++) put_raw(1'b1);
        end else begin
            exp_sym[exp_n] = 2'b10; exp_n++;           // R6 SE0
            exp_sym[exp_n] = 2'b10; exp_n++;
            exp_sym[exp_n] = 2'b01; exp_n++;           // R6 J
        end
    endtask

    task automatic run_packet(input bit hs, input int period, input int lead);
        int   cap      = 0;
        int   cyc      = 0;
        int   idx      = 0;
        int   guard    = 0;
        bit   pend     = 0;
        bit   dropped  = 0;
        int   ready_bad = 0;
        int   quiet_bad = 0;
        int   idle_bad  = 0;
        int   mism     = -1;
        int   mism_act = 0;
        int   mism_exp = 0;
        logic [1:0] got;
        string tag;
        build_expected(hs);
        tag = hs ? "R3 R4 R5 R7 R8" : "R2 R4 R5 R6 R8";
        @(negedge clk);
        hs_mode  = hs;
        bit_en   = 1'b0;
        tx_data  = pkt[0];
        tx_valid = 1'b1;
        while (cap < exp_n + 2 && guard < 20000) begin
            @(negedge clk);
            guard++;
            got = {line_se0, line_dat};
            if (bit_en) begin
                if (cap < exp_n) begin
                    if (got !== exp_sym[cap] && mism < 0) begin
                        mism = cap; mism_act = int'(got); mism_exp = int'(exp_sym[cap]);
                    end
                end else if (got !== {hs, 1'b1}) begin
                    idle_bad++;
                end
                cap++;
            end else if (cap == 0 && cyc >= 1 && got !== {hs, 1'b1}) begin
                quiet_bad++;
            end
            if (dropped && cap < exp_n && tx_ready) ready_bad++;
            if (pend) begin
                idx++;
                if (idx < plen) tx_data = pkt[idx];
                else begin
                    tx_valid = 1'b0;
                    dropped  = 1;
                end
            end
            pend = tx_valid && tx_ready;
            cyc++;
            bit_en = (cyc >= 3 + lead) && ((cyc % period) == 0);
        end
        bit_en = 1'b0;
        check(guard < 20000, tag, "packet did not finish", guard, 20000);
        check(mism < 0, tag, $sformatf("symbol %0d {se0,dat}", mism), mism_act, mism_exp);
        check(ready_bad == 0, "R9", "tx_ready high after tx_valid fell", ready_bad, 0);
        check(quiet_bad == 0, "R10", "line moved before first strobe", quiet_bad, 0);
        check(idle_bad == 0, "R1", "line not idle after packet", idle_bad, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n    = 1'b0;
        hs_mode  = 1'b0;
        bit_en   = 1'b0;
        tx_data  = '0;
        tx_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_ready === 1'b0, "R1", "tx_ready in reset", int'(tx_ready), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({line_se0, line_dat} === 2'b01, "R1", "FS idle", int'({line_se0, line_dat}), 1);
        check(tx_ready === 1'b0, "R1", "tx_ready idle", int'(tx_ready), 0);
        hs_mode = 1'b1;
        repeat (2) @(negedge clk);
        check({line_se0, line_dat} === 2'b11, "R1", "HS idle", int'({line_se0, line_dat}), 3);

        // Directed: payload ends on six ones (R5, R6, R7)
        plen = 1; pkt[0] = 8'hFC;
        run_packet(1'b0, 2, 0);
        run_packet(1'b1, 2, 0);
        plen = 2; pkt[0] = 8'hFF; pkt[1] = 8'hFF;
        run_packet(1'b1, 1, 4);
        run_packet(1'b0, 3, 1);
        plen = 2; pkt[0] = 8'h00; pkt[1] = 8'hA5;
        run_packet(1'b0, 4, 2);
        run_packet(1'b1, 1, 0);

        // Random packets
        for (int n = 0; n < 24; n++) begin
            plen = 1 + int'($urandom % 6);
            for (int k = 0; k < plen; k++)
                pkt[k] = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
            run_packet(1'($urandom % 2), 1 + int'($urandom % 4), int'($urandom % 5));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule